// File: doc/BRIEF.md
# Adaptive-Direction Skew Correction Loop

This block closes the digital half of a sampling-skew calibration loop in a multi-channel interleaved converter. For each channel it keeps a 9-bit delay control word, and it moves that word with a signed error that an upstream estimator reports once per block of samples. The sign relating error to delay is not fixed: it changes with the Nyquist band that holds the input signal. The loop therefore learns the sign itself before it starts to integrate.

A start pulse opens a short probe on one chosen channel. The first error moves that channel's word in a default direction. The second error is compared with the first. If the error grew without changing sign, the direction is reversed and the probed word goes back to the value it had at start. After the probe the loop tracks: every later error nudges the word of the channel it belongs to, with saturation at both ends of the code range. The step size is a right shift of the error.

Top module: `skew_dir_loop`

## Requirements
- R1: After reset every channel word equals 256, `dir_pos_o` is 0 (direction −1) and `fine_o` is 0.
- R2: A start pulse clears `dir_pos_o` to 0, clears `fine_o` to 0 and latches `ch_sel_i` as the probe channel. A start pulse changes no word. An error strobe in the same cycle as start is ignored.
- R3: The first strobe after start sets the probe channel's word to the value before the strobe plus (`err_i` >>> `mu_shift_i`). This is an arithmetic right shift, so it rounds toward minus infinity (−3 shifted by 1 gives −2). The result is saturated to 0..511.
- R4: While `fine_o` is 0 after a start, only the probe channel's word may change, whatever value `ch_sel_i` takes. Cycles without a strobe change no word in any phase.
- R5: On the second strobe after start, if both errors are nonzero with the same sign and the second magnitude is strictly larger, `dir_pos_o` becomes 1, the probe channel's word returns to its value at start, and `fine_o` becomes 1.
- R6: On the second strobe in every other case (smaller or equal magnitude, opposite signs, either error zero), `dir_pos_o` stays 0, no word changes, and `fine_o` becomes 1.
- R7: With `fine_o` at 1, each strobe changes only the word of channel `ch_sel_i`. It adds the shifted error when `dir_pos_o` is 0 and subtracts it when `dir_pos_o` is 1. `fine_o` stays 1 until the next start.
- R8: Word updates saturate at 0 and 511 and never wrap.
- R9: Strobes received after reset and before the first start change no word and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a direction probe |
| err_vld_i | input | 1 | Error strobe, one per sample block |
| err_i | input | 12 | Signed skew error |
| ch_sel_i | input | 2 | Probe channel at start; target channel while tracking |
| mu_shift_i | input | 3 | Step size as a right-shift count |
| words_o | output | 36 | Delay words, channel k at bits 9k+8..9k |
| dir_pos_o | output | 1 | Learned direction: 0 is −1, 1 is +1 |
| fine_o | output | 1 | 1 while in the tracking phase |

## Verification
Some properties are checked on every cycle. Words hold still when no strobe arrives or when the loop has not started. At most one channel's word moves in any cycle. A start returns both flags to their probe values. The direction flag can rise only in the cycle that tracking begins, and tracking persists. The arithmetic values depend on the signs and magnitudes of two successive errors and on the shift. These are shown only by the bench scenarios, which compare every word against a model. Those scenarios cover the reversal and restore, the overshoot and equal-magnitude cases, clipping at both rails, and shift rounding.

// File: rtl/skewcal_pkg.sv
`timescale 1ns/1ps
package skewcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE1 = 2'd1,
    ST_PROBE2 = 2'd2,
    ST_TRACK  = 2'd3
  } phase_e;
endpackage

// File: rtl/skew_step.sv
`timescale 1ns/1ps
// Saturating add/subtract of a shifted signed error onto an unsigned word.
module skew_step #(
  parameter int WW = 9,
  parameter int EW = 12,
  parameter int SW = 3
) (
  input  logic [WW-1:0]        word_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [SW-1:0]        shift_i,
  input  logic                 neg_i,
  output logic [WW-1:0]        word_o
);
  localparam int AW = EW + 2;

  logic signed [EW-1:0] delta;
  logic signed [AW-1:0] base, dext, sum, top;

  always_comb begin
    delta = err_i >>> shift_i;
    base  = $signed({{(AW-WW){1'b0}}, word_i});
    dext  = {{2{delta[EW-1]}}, delta};
    top   = $signed({{(AW-WW){1'b0}}, {WW{1'b1}}});
    sum   = neg_i ? (base - dext) : (base + dext);
    if (sum < 0)
      word_o = '0;
    else if (sum > top)
      word_o = '1;
    else
      word_o = sum[WW-1:0];
  end
endmodule

// File: rtl/skew_dir_fsm.sv
`timescale 1ns/1ps
// Probe/track sequencer: learns the integration sign from two errors.
module skew_dir_fsm
  import skewcal_pkg::*;
#(
  parameter int NCH = 4,
  parameter int EW  = 12,
  parameter int CW  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 vld_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [CW-1:0]        ch_i,
  output phase_e               phase_o,
  output logic                 dir_pos_o,
  output logic [CW-1:0]        probe_ch_o,
  output logic                 probe_upd_o,
  output logic                 flip_o
);
  phase_e               phase_q, phase_d;
  logic                 dir_q, dir_d;
  logic [CW-1:0]        pch_q, pch_d;
  logic signed [EW-1:0] e1_q, e1_d;
  logic                 same_sign, grew;

  function automatic logic [EW:0] mag(input logic signed [EW-1:0] v);
    logic signed [EW:0] x;
    x = {v[EW-1], v};
    return x[EW] ? $unsigned(-x) : $unsigned(x);
  endfunction

  always_comb begin
    same_sign = ((e1_q > 0) && (err_i > 0)) || ((e1_q < 0) && (err_i < 0));
    grew      = same_sign && (mag(err_i) > mag(e1_q));
  end

  always_comb begin
    phase_d     = phase_q;
    dir_d       = dir_q;
    pch_d       = pch_q;
    e1_d        = e1_q;
    probe_upd_o = 1'b0;
    flip_o      = 1'b0;
    if (start_i) begin
      phase_d = ST_PROBE1;
      dir_d   = 1'b0;
      pch_d   = ch_i;
    end else if (vld_i) begin
      unique case (phase_q)
        ST_PROBE1: begin
          probe_upd_o = 1'b1;
          e1_d        = err_i;
          phase_d     = ST_PROBE2;
        end
        ST_PROBE2: begin
          flip_o  = grew;
          dir_d   = grew ? 1'b1 : dir_q;
          phase_d = ST_TRACK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      dir_q   <= 1'b0;
      pch_q   <= '0;
      e1_q    <= '0;
    end else begin
      phase_q <= phase_d;
      dir_q   <= dir_d;
      pch_q   <= pch_d;
      e1_q    <= e1_d;
    end
  end

  assign phase_o    = phase_q;
  assign dir_pos_o  = dir_q;
  assign probe_ch_o = pch_q;
endmodule

// File: rtl/skew_dir_loop.sv
`timescale 1ns/1ps
module skew_dir_loop
  import skewcal_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int WW   = 9,
  parameter int EW   = 12,
  parameter int SW   = 3,
  parameter int INIT = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    err_vld_i,
  input  logic signed [EW-1:0]    err_i,
  input  logic [$clog2(NCH)-1:0]  ch_sel_i,
  input  logic [SW-1:0]           mu_shift_i,
  output logic [NCH*WW-1:0]       words_o,
  output logic                    dir_pos_o,
  output logic                    fine_o
);
  localparam int CW = $clog2(NCH);

  phase_e        phase_q;
  logic [CW-1:0] probe_ch, tgt;
  logic          probe_upd, flip, upd_en, dir_pos;
  logic [WW-1:0] word_q [NCH];
  logic [WW-1:0] word_d [NCH];
  logic [WW-1:0] snap_q, snap_d, cur_word, new_word;

  skew_dir_fsm #(.NCH(NCH), .EW(EW), .CW(CW)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .vld_i      (err_vld_i),
    .err_i      (err_i),
    .ch_i       (ch_sel_i),
    .phase_o    (phase_q),
    .dir_pos_o  (dir_pos),
    .probe_ch_o (probe_ch),
    .probe_upd_o(probe_upd),
    .flip_o     (flip)
  );

  always_comb begin
    tgt      = (phase_q == ST_TRACK) ? ch_sel_i : probe_ch;
    upd_en   = probe_upd || ((phase_q == ST_TRACK) && err_vld_i && !start_i);
    cur_word = word_q[tgt];
    snap_d   = start_i ? word_q[ch_sel_i] : snap_q;
  end

  skew_step #(.WW(WW), .EW(EW), .SW(SW)) step_i (
    .word_i (cur_word),
    .err_i  (err_i),
    .shift_i(mu_shift_i),
    .neg_i  (dir_pos),
    .word_o (new_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= WW'(INIT);
    else        snap_q <= snap_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      word_d[i] = word_q[i];
      if (upd_en && (tgt == CW'(i)))
        word_d[i] = new_word;
      if (flip && (probe_ch == CW'(i)))
        word_d[i] = snap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= WW'(INIT);
      else        word_q[i] <= word_d[i];
    end

    assign words_o[i*WW +: WW] = word_q[i];
  end

  assign dir_pos_o = dir_pos;
  assign fine_o    = (phase_q == ST_TRACK);
endmodule

// File: rtl/skew_dir_loop_chk.sv
`timescale 1ns/1ps
module skew_dir_loop_chk
  import skewcal_pkg::*;
#(
  parameter int NCH = 4,
  parameter int WW  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              err_vld_i,
  input logic [NCH*WW-1:0] words_o,
  input logic              dir_pos_o,
  input logic              fine_o,
  input phase_e            phase_q
);
  logic [NCH*WW-1:0] prev_q;
  logic              prev_ok;
  logic [NCH-1:0]    chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      prev_ok <= 1'b0;
    end else begin
      prev_q  <= words_o;
      prev_ok <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chg
    assign chg[i] = (words_o[i*WW +: WW] != prev_q[i*WW +: WW]);
  end

  a_r2_start_resets: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!fine_o && !dir_pos_o));

  a_r4_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld_i |=> $stable(words_o));

  a_r5_flip_enters_track: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_pos_o) |-> $rose(fine_o));

  a_r7_track_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_o && !start_i) |=> fine_o);

  a_r7_one_word_moves: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> ($countones(chg) <= 1));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_IDLE) |=> $stable(words_o));
endmodule

bind skew_dir_loop skew_dir_loop_chk #(.NCH(NCH), .WW(WW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .err_vld_i(err_vld_i),
  .words_o  (words_o),
  .dir_pos_o(dir_pos_o),
  .fine_o   (fine_o),
  .phase_q  (phase_q)
);

// File: tb/skew_dir_loop_tb_top.sv
`timescale 1ns/1ps
module skew_dir_loop_tb_top;
  localparam int NCH = 4;
  localparam int WW  = 9;
  localparam int EW  = 12;
  localparam int SW  = 3;
  localparam int CW  = 2;
  localparam int MAXW = 511;

  logic                 clk;
  logic                 rst_n;
  logic                 start_i;
  logic                 err_vld_i;
  logic signed [EW-1:0] err_i;
  logic [CW-1:0]        ch_sel_i;
  logic [SW-1:0]        mu_shift_i;
  logic [NCH*WW-1:0]    words_o;
  logic                 dir_pos_o;
  logic                 fine_o;

  int vectors;
  int miscompares;

  int mw [NCH];
  int mcd;
  int mph;
  int mtch;
  int me1;
  int msnap;

  skew_dir_loop #(.NCH(NCH), .WW(WW), .EW(EW), .SW(SW), .INIT(256)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .err_vld_i (err_vld_i),
    .err_i     (err_i),
    .ch_sel_i  (ch_sel_i),
    .mu_shift_i(mu_shift_i),
    .words_o   (words_o),
    .dir_pos_o (dir_pos_o),
    .fine_o    (fine_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int clampw(input int v);
    if (v < 0) return 0;
    if (v > MAXW) return MAXW;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic compare(input string tag);
    bit    bad;
    string msg;
    bad = 0;
    vectors++;
    for (int i = 0; i < NCH; i++) begin
      if (!bad && (int'(words_o[i*WW +: WW]) != mw[i])) begin
        bad = 1;
        $sformat(msg, "word[%0d] actual %0d expected %0d", i, words_o[i*WW +: WW], mw[i]);
      end
    end
    if (!bad && (int'(dir_pos_o) != mcd)) begin
      bad = 1;
      $sformat(msg, "dir_pos_o actual %0d expected %0d", dir_pos_o, mcd);
    end
    if (!bad && (int'(fine_o) != ((mph == 3) ? 1 : 0))) begin
      bad = 1;
      $sformat(msg, "fine_o actual %0d expected %0d", fine_o, (mph == 3) ? 1 : 0);
    end
    if (bad) begin
      miscompares++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic step(input bit st, input bit vl, input int e, input int ch, input int sh);
    string tag;
    int    d;
    int    raw;
    bit    worse;
    d = e >>> sh;
    if (st) begin
      tag   = "R2";
      msnap = mw[ch];
      mph   = 1;
      mcd   = 0;
      mtch  = ch;
    end else if (vl) begin
      case (mph)
        0: tag = "R9";
        1: begin
          tag = "R3";
          mw[mtch] = clampw(mw[mtch] + d);
          me1 = e;
          mph = 2;
        end
        2: begin
          worse = (((me1 > 0) && (e > 0)) || ((me1 < 0) && (e < 0))) && (iabs(e) > iabs(me1));
          if (worse) begin
            tag = "R5";
            mcd = 1;
            mw[mtch] = msnap;
          end else begin
            tag = "R6";
          end
          mph = 3;
        end
        default: begin
          raw = (mcd == 1) ? (mw[ch] - d) : (mw[ch] + d);
          tag = ((raw < 0) || (raw > MAXW)) ? "R8" : "R7";
          mw[ch] = clampw(raw);
        end
      endcase
    end else begin
      tag = (mph == 1 || mph == 2) ? "R4" : ((mph == 0) ? "R9" : "R7");
    end
    start_i    = st;
    err_vld_i  = vl;
    err_i      = EW'(e);
    ch_sel_i   = CW'(ch);
    mu_shift_i = SW'(sh);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic int rand_err();
    int k;
    k = int'($urandom_range(3, 0));
    if (k == 0) return int'($urandom_range(40, 0)) - 20;
    return int'($urandom_range(4095, 0)) - 2048;
  endfunction

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vectors = 0;
    miscompares = 0;
    void'($urandom(32'h5eed_0123));
    rst_n = 1'b0;
    start_i = 1'b0;
    err_vld_i = 1'b0;
    err_i = '0;
    ch_sel_i = '0;
    mu_shift_i = '0;
    for (int i = 0; i < NCH; i++) mw[i] = 256;
    mcd = 0; mph = 0; mtch = 0; me1 = 0; msnap = 256;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R9: strobes before any start
    step(0, 1, 900, 1, 0);
    step(0, 1, -900, 2, 0);

    // R5: probe on ch2, error grows with same sign -> reverse, restore
    step(1, 0, 0, 2, 0);
    step(0, 1, 100, 3, 2);      // R3: 256 + 25, ch_sel ignored (R4)
    step(0, 0, 0, 1, 0);
    step(0, 1, 200, 0, 2);      // R5
    step(0, 1, 40, 1, 0);       // R7 subtract: 216

    // R6: overshoot on ch0 keeps direction
    step(1, 0, 0, 0, 0);
    step(0, 1, -64, 0, 1);      // R3: 256-32
    step(0, 1, 10, 2, 0);       // R6 opposite signs
    step(0, 1, 2047, 3, 0);     // R8 clip high
    step(0, 1, -2048, 3, 0);    // R8 clip low
    step(0, 1, -3, 1, 1);       // R3 rounding: -2

    // R6: equal magnitude, and R2 start with simultaneous strobe
    step(1, 1, 500, 1, 0);
    step(0, 1, 30, 1, 0);
    step(0, 1, 30, 1, 0);       // R6 equal
    step(1, 0, 0, 3, 0);
    step(0, 1, 0, 3, 0);        // zero first error
    step(0, 1, 50, 3, 0);       // R6

    for (int n = 0; n < 4000; n++) begin
      step(($urandom_range(39, 0) == 0), ($urandom_range(1, 0) == 1),
           rand_err(), int'($urandom_range(NCH-1, 0)), int'($urandom_range(7, 0)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule